// File: doc/BRIEF.md
# Ring Node Packet Forwarder

This block is one station in a loop of identical stations joined by asynchronous serial links: the serial output of each station drives the serial input of the next. Every byte that arrives is sent on downstream after one byte of store-and-forward delay. The station also reads the first byte of each packet to decide whether the packet is meant for it. When it is, the station validates writes with a CRC-8 and performs them through a simple register port. It answers reads by inserting register bytes and a CRC-8 into the outgoing stream, directly after the request.

A station that has not yet been given an address takes the first packet sent to address 0. It marks that packet as taken by setting the top bit of the header as it passes the header on, so stations further down the loop leave the packet alone. A write of the address register then gives the station a fixed address. From then on it answers only to that address and to the broadcast address. Baud-rate generation and register storage are outside the block: the bit time is a parameter in clocks, and the registers sit behind the port.

Top module: `ring_node`

## Requirements
- R1: Every byte received on `rxLine` is retransmitted on `txLine` in the same order. The format is 8N1, LSB first, with `CLKS_PER_BIT` clocks per bit. Only the header may be altered, and only as R3 describes.
- R2: During and after reset, `txLine` is high and `regWrEn` and `regRdEn` are low until a packet is received.
- R3: The header layout is bit 7 = taken flag, bits 6:1 = station address, bit 0 = 1 for write and 0 for read. While no address is assigned, a header whose bits 7:1 are all zero is sent on with bit 7 set and bit 0 kept, and the station acts on that packet.
- R4: A header with bit 7 already set is sent on unchanged and is not acted on. The station skips the packet's length: a write packet is 4 bytes, and a read packet is 3 bytes plus count plus 1.
- R5: A write packet is header, register address, one data byte, CRC. The station pulses `regWrEn` for one cycle only when the CRC byte matches.
- R6: A read packet is header, register address, count. The station inserts count bytes read from the register address upward, wrapping modulo 256, and then a CRC byte. `regRdEn` pulses once per byte and is never high together with `regWrEn`.
- R7: The CRC uses polynomial 0x07 with an initial value of 0, processed MSB first. It covers every byte of the packet as received (the header before any marking), followed by the inserted read bytes.
- R8: A write to register 0x3B whose data has bit 7 set assigns data bits 5:0 as the station address, and the address is kept until reset. After that, headers with bits 7:1 all zero are sent on unchanged and are ignored.
- R9: An addressed station acts on headers whose bits 6:1 equal its address. It sends other addresses on unchanged and does not act on them.
- R10: A write to broadcast address 0x3F is acted on by every station, whether or not it has an address, and the header is sent on unchanged. A read to 0x3F is not acted on.
- R11: If no byte arrives for more than `IDLE_BYTES` byte times while a packet is incomplete, the station returns to expecting a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxLine | input | 1 | Serial input from the upstream station |
| txLine | output | 1 | Serial output to the downstream station |
| regAddr | output | 8 | Register address for reads and writes |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrData | output | 8 | Register write data |
| regRdEn | output | 1 | One-cycle register read strobe; data is sampled in the same cycle |
| regRdData | input | 8 | Register read data, valid combinationally for `regAddr` |

## Verification
The bench builds the station with `CLKS_PER_BIT` = 8, `IDLE_BYTES` = 2 and `FIFO_DEPTH` = 4. The short bit time lets a single run cover claiming, bad-CRC and good-CRC writes, address assignment, own-address reads that wrap past register 0xFF, broadcast traffic and the mid-packet idle timeout. With a two-byte timeout, a stalled partial packet can be followed at once by a full request, which shows whether the parser resynchronised. A four-entry output queue holds the inserted reply bytes while the transmitter is still sending the forwarded request.

// File: rtl/ring_node_pkg.sv
package ring_node_pkg;

  typedef enum logic [2:0] {
    S_HEAD, S_REGA, S_WDATA, S_WCRC, S_RCNT, S_REPLY, S_RCRC, S_SKIP
  } parseState_t;

  typedef enum logic [1:0] {
    PUSH_HDR, PUSH_RAW, PUSH_RDATA, PUSH_CRC
  } pushSel_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic     push;
    pushSel_t pushSel;
    logic     crcStart;
    logic     crcRx;
    logic     crcRd;
    logic     latchReg;
    logic     latchData;
    logic     rdStep;
    logic     wrFire;
  } ctrlStrobe_t;

  // One byte folded into a CRC-8, polynomial 0x07, MSB first
  function automatic logic [7:0] crc8Step(input logic [7:0] crcIn, input logic [7:0] dataIn);
    logic [7:0] acc;
    acc = crcIn ^ dataIn;
    for (int i = 0; i < 8; i++) begin
      acc = acc[7] ? ((acc << 1) ^ 8'h07) : (acc << 1);
    end
    return acc;
  endfunction

endpackage

// File: rtl/node_uart_rx.sv
module node_uart_rx #(
  parameter int CLKS_PER_BIT = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxLine,
  output logic       byteValid,
  output logic [7:0] byteData
);
  localparam int CW = $clog2(CLKS_PER_BIT + 1);
  localparam logic [CW-1:0] HALF_T = CW'(CLKS_PER_BIT / 2 - 1);
  localparam logic [CW-1:0] LAST_T = CW'(CLKS_PER_BIT - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rxState_t;

  logic [1:0]    syncQ;
  rxState_t      rxState;
  logic [CW-1:0] tick;
  logic [2:0]    bitIdx;
  logic [7:0]    shiftQ;
  logic          lineS;

  assign lineS = syncQ[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ     <= 2'b11;
      rxState   <= RX_IDLE;
      tick      <= '0;
      bitIdx    <= '0;
      shiftQ    <= '0;
      byteValid <= 1'b0;
      byteData  <= '0;
    end else begin
      syncQ     <= {syncQ[0], rxLine};
      byteValid <= 1'b0;
      case (rxState)
        RX_IDLE: begin
          tick <= '0;
          if (!lineS) rxState <= RX_START;
        end
        RX_START: begin
          if (tick == HALF_T) begin
            tick    <= '0;
            bitIdx  <= '0;
            rxState <= lineS ? RX_IDLE : RX_DATA;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        RX_DATA: begin
          if (tick == LAST_T) begin
            tick   <= '0;
            shiftQ <= {lineS, shiftQ[7:1]};
            if (bitIdx == 3'd7) rxState <= RX_STOP;
            else                bitIdx  <= bitIdx + 1'b1;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        default: begin
          if (tick == LAST_T) begin
            tick    <= '0;
            rxState <= RX_IDLE;
            if (lineS) begin
              byteValid <= 1'b1;
              byteData  <= shiftQ;
            end
          end else begin
            tick <= tick + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/node_uart_tx.sv
module node_uart_tx #(
  parameter int CLKS_PER_BIT = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadEn,
  input  logic [7:0] loadData,
  output logic       busy,
  output logic       txLine
);
  localparam int CW = $clog2(CLKS_PER_BIT + 1);
  localparam logic [CW-1:0] LAST_T = CW'(CLKS_PER_BIT - 1);

  logic [8:0]    frameQ;
  logic [3:0]    bitsLeft;
  logic [CW-1:0] tick;

  assign busy = (bitsLeft != 4'd0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameQ   <= '1;
      bitsLeft <= '0;
      tick     <= '0;
      txLine   <= 1'b1;
    end else if (!busy) begin
      tick <= '0;
      if (loadEn) begin
        frameQ   <= {1'b1, loadData};
        bitsLeft <= 4'd10;
        txLine   <= 1'b0;
      end
    end else if (tick == LAST_T) begin
      tick     <= '0;
      bitsLeft <= bitsLeft - 1'b1;
      txLine   <= (bitsLeft == 4'd1) ? 1'b1 : frameQ[0];
      frameQ   <= {1'b1, frameQ[8:1]};
    end else begin
      tick <= tick + 1'b1;
    end
  end
endmodule

// File: rtl/node_datapath.sv
module node_datapath
  import ring_node_pkg::*;
#(
  parameter int          CLKS_PER_BIT = 40,
  parameter int          FIFO_DEPTH   = 4,
  parameter logic [5:0]  BCAST_ADDR   = 6'h3F,
  parameter logic [7:0]  ADDR_REG     = 8'h3B
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxLine,
  output logic        txLine,
  input  ctrlStrobe_t ctl,
  output logic        rxValid,
  output logic [7:0]  rxByte,
  output logic        hdrMine,
  output logic        hdrWrite,
  output logic        crcMatch,
  output logic        fifoFull,
  output logic        assigned,
  output logic [7:0]  regAddr,
  output logic        regWrEn,
  output logic [7:0]  regWrData,
  output logic        regRdEn,
  input  logic [7:0]  regRdData
);
  localparam int PW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam logic [PW:0] FULL_N = (PW + 1)'(FIFO_DEPTH);

  logic [5:0] myAddr;
  logic [7:0] crcQ, regPtr, dataQ, hdrOut, pushData;
  logic       claimable, wrQ;

  node_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .byteValid(rxValid), .byteData(rxByte)
  );

  // Header decode
  assign claimable = !assigned && (rxByte[7:1] == 7'd0);
  assign hdrMine   = !rxByte[7] &&
                     (claimable ||
                      (assigned && rxByte[6:1] == myAddr) ||
                      (rxByte[6:1] == BCAST_ADDR && rxByte[0]));
  assign hdrWrite  = rxByte[0];
  assign hdrOut    = claimable ? (rxByte | 8'h80) : rxByte;
  assign crcMatch  = (rxByte == crcQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcQ     <= '0;
      regPtr   <= '0;
      dataQ    <= '0;
      wrQ      <= 1'b0;
      myAddr   <= '0;
      assigned <= 1'b0;
    end else begin
      if (ctl.crcStart)   crcQ <= crc8Step(8'h00, rxByte);
      else if (ctl.crcRx) crcQ <= crc8Step(crcQ, rxByte);
      else if (ctl.crcRd) crcQ <= crc8Step(crcQ, regRdData);
      if (ctl.latchReg)    regPtr <= rxByte;
      else if (ctl.rdStep) regPtr <= regPtr + 1'b1;
      if (ctl.latchData) dataQ <= rxByte;
      wrQ <= ctl.wrFire;
      if (ctl.wrFire && regPtr == ADDR_REG && dataQ[7]) begin
        myAddr   <= dataQ[5:0];
        assigned <= 1'b1;
      end
    end
  end

  assign regAddr   = regPtr;
  assign regWrEn   = wrQ;
  assign regWrData = dataQ;
  assign regRdEn   = ctl.rdStep;

  // Output queue feeding the transmitter
  always_comb begin
    case (ctl.pushSel)
      PUSH_HDR:   pushData = hdrOut;
      PUSH_RAW:   pushData = rxByte;
      PUSH_RDATA: pushData = regRdData;
      default:    pushData = crcQ;
    endcase
  end

  logic [7:0]    fifoMem [FIFO_DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [PW:0]   fill;
  logic          doPush, doPop, txBusy;

  assign fifoFull = (fill == FULL_N);
  assign doPush   = ctl.push && !fifoFull;
  assign doPop    = !txBusy && (fill != '0);

  always_ff @(posedge clk) begin
    if (doPush) fifoMem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  node_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk(clk), .rstN(rstN), .loadEn(doPop), .loadData(fifoMem[rdPtr]),
    .busy(txBusy), .txLine(txLine)
  );
endmodule

// File: rtl/node_control.sv
module node_control
  import ring_node_pkg::*;
#(
  parameter int CLKS_PER_BIT = 40,
  parameter int IDLE_BYTES   = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic [7:0]  rxByte,
  input  logic        hdrMine,
  input  logic        hdrWrite,
  input  logic        crcMatch,
  input  logic        fifoFull,
  output ctrlStrobe_t ctl
);
  localparam int IDLE_LIMIT = IDLE_BYTES * 10 * CLKS_PER_BIT;
  localparam int IW = $clog2(IDLE_LIMIT + 1);
  localparam logic [IW-1:0] IDLE_MAX = IW'(IDLE_LIMIT);

  parseState_t state, nextState;
  logic        mineQ, writeQ, waiting;
  logic [8:0]  leftQ;
  logic [IW-1:0] idleQ;

  assign waiting = (state == S_REGA) || (state == S_WDATA) || (state == S_WCRC) ||
                   (state == S_RCNT) || (state == S_SKIP);

  always_comb begin
    ctl       = '0;
    nextState = state;
    if (rxValid) begin
      ctl.push    = 1'b1;
      ctl.pushSel = (state == S_HEAD) ? PUSH_HDR : PUSH_RAW;
    end
    case (state)
      S_HEAD: if (rxValid) begin
        ctl.crcStart = 1'b1;
        nextState    = S_REGA;
      end
      S_REGA: if (rxValid) begin
        ctl.crcRx    = 1'b1;
        ctl.latchReg = 1'b1;
        nextState    = writeQ ? S_WDATA : S_RCNT;
      end
      S_WDATA: if (rxValid) begin
        ctl.crcRx     = 1'b1;
        ctl.latchData = 1'b1;
        nextState     = S_WCRC;
      end
      S_WCRC: if (rxValid) begin
        ctl.wrFire = mineQ && crcMatch;
        nextState  = S_HEAD;
      end
      S_RCNT: if (rxValid) begin
        ctl.crcRx = 1'b1;
        if (!mineQ)               nextState = S_SKIP;
        else if (rxByte == 8'd0)  nextState = S_RCRC;
        else                      nextState = S_REPLY;
      end
      S_REPLY: if (!rxValid && !fifoFull) begin
        ctl.rdStep  = 1'b1;
        ctl.crcRd   = 1'b1;
        ctl.push    = 1'b1;
        ctl.pushSel = PUSH_RDATA;
        if (leftQ == 9'd1) nextState = S_RCRC;
      end
      S_RCRC: if (!rxValid && !fifoFull) begin
        ctl.push    = 1'b1;
        ctl.pushSel = PUSH_CRC;
        nextState   = S_HEAD;
      end
      default: if (rxValid && leftQ == 9'd1) nextState = S_HEAD;
    endcase
    if (!rxValid && waiting && idleQ == IDLE_MAX) nextState = S_HEAD;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_HEAD;
      mineQ  <= 1'b0;
      writeQ <= 1'b0;
      leftQ  <= '0;
      idleQ  <= '0;
    end else begin
      state <= nextState;
      if (state == S_HEAD && rxValid) begin
        mineQ  <= hdrMine;
        writeQ <= hdrWrite;
      end
      if (state == S_RCNT && rxValid)
        leftQ <= mineQ ? {1'b0, rxByte} : ({1'b0, rxByte} + 9'd1);
      else if (ctl.rdStep || (state == S_SKIP && rxValid))
        leftQ <= leftQ - 1'b1;
      if (rxValid || !waiting)   idleQ <= '0;
      else if (idleQ != IDLE_MAX) idleQ <= idleQ + 1'b1;
    end
  end
endmodule

// File: rtl/ring_node.sv
module ring_node
  import ring_node_pkg::*;
#(
  parameter int         CLKS_PER_BIT = 40,
  parameter int         FIFO_DEPTH   = 4,
  parameter int         IDLE_BYTES   = 2,
  parameter logic [5:0] BCAST_ADDR   = 6'h3F,
  parameter logic [7:0] ADDR_REG     = 8'h3B
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxLine,
  output logic       txLine,
  output logic [7:0] regAddr,
  output logic       regWrEn,
  output logic [7:0] regWrData,
  output logic       regRdEn,
  input  logic [7:0] regRdData
);
  ctrlStrobe_t ctl;
  logic        rxValid, hdrMine, hdrWrite, crcMatch, fifoFull, assigned;
  logic [7:0]  rxByte;

  node_datapath #(
    .CLKS_PER_BIT(CLKS_PER_BIT), .FIFO_DEPTH(FIFO_DEPTH),
    .BCAST_ADDR(BCAST_ADDR), .ADDR_REG(ADDR_REG)
  ) u_dp (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .txLine(txLine), .ctl(ctl),
    .rxValid(rxValid), .rxByte(rxByte), .hdrMine(hdrMine), .hdrWrite(hdrWrite),
    .crcMatch(crcMatch), .fifoFull(fifoFull), .assigned(assigned),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData)
  );

  node_control #(.CLKS_PER_BIT(CLKS_PER_BIT), .IDLE_BYTES(IDLE_BYTES)) u_ctl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxByte(rxByte),
    .hdrMine(hdrMine), .hdrWrite(hdrWrite), .crcMatch(crcMatch),
    .fifoFull(fifoFull), .ctl(ctl)
  );
endmodule

// File: rtl/ring_node_checker.sv
module ring_node_checker (
  input logic       clk,
  input logic       rstN,
  input logic       rxValid,
  input logic       pushEn,
  input logic       fifoFull,
  input logic       regWrEn,
  input logic       regRdEn,
  input logic [7:0] regAddr,
  input logic       assigned
);
  // R1: a received byte is always queued for retransmission
  p_forward_r1: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && !fifoFull |-> pushEn);

  // R6: read and write strobes never coincide
  p_rw_exclusive_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdEn));

  // R5: a write strobe lasts one cycle
  p_wr_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  // R6: each read byte advances the register address by one
  p_rd_advance_r6: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> regAddr == $past(regAddr) + 8'd1);

  // R8: an assigned address is kept
  p_addr_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    assigned |=> assigned);
endmodule

bind ring_node ring_node_checker u_chk (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .pushEn(ctl.push),
  .fifoFull(fifoFull), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regAddr(regAddr), .assigned(assigned)
);

// File: tb/ring_node_bench.sv
module ring_node_bench;
  localparam int CPB = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxLine = 1'b1;
  logic txLine, regWrEn, regRdEn;
  logic [7:0] regAddr, regWrData, regRdData;

  always #2 clk = ~clk;

  ring_node #(.CLKS_PER_BIT(CPB), .FIFO_DEPTH(4), .IDLE_BYTES(2)) u_ring_node (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .txLine(txLine),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData)
  );

  // Register model behind the port
  logic [7:0] regs [256];
  int wrCnt = 0, rdCnt = 0;
  assign regRdData = regs[regAddr];

  always @(negedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) regs[i] = 8'(i) ^ 8'h5A;
    end else begin
      if (regWrEn) begin regs[regAddr] = regWrData; wrCnt++; end
      if (regRdEn) rdCnt++;
    end
  end

  // Serial monitor on txLine
  logic [7:0] outBuf [256];
  int outCnt = 0;
  initial begin
    logic [7:0] v;
    forever begin
      @(negedge clk);
      if (rstN && txLine == 1'b0) begin
        repeat (CPB / 2) @(negedge clk);
        for (int b = 0; b < 8; b++) begin
          repeat (CPB) @(negedge clk);
          v[b] = txLine;
        end
        repeat (CPB) @(negedge clk);
        outBuf[outCnt[7:0]] = v;
        outCnt++;
      end
    end
  end

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] expQ[$];

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] crcAdd(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r = c;
    for (int k = 7; k >= 0; k--) begin
      logic fb = r[7] ^ d[k];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h07;
    end
    return r;
  endfunction

  function automatic logic [7:0] crcOf(input logic [7:0] q[$]);
    logic [7:0] c = 8'h00;
    foreach (q[i]) c = crcAdd(c, q[i]);
    return c;
  endfunction

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk) rxLine = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxLine = b[i];
      repeat (CPB) @(negedge clk);
    end
    rxLine = 1'b1;
    repeat (CPB) @(negedge clk);
  endtask

  task automatic sendAll(input logic [7:0] q[$]);
    foreach (q[i]) sendByte(q[i]);
  endtask

  task automatic settle();
    repeat (2000) @(negedge clk);
  endtask

  task automatic compareOut(input string req, input int base);
    chk(req, "byte count", outCnt - base, expQ.size());
    foreach (expQ[i])
      if (base + i < outCnt) chk(req, $sformatf("byte %0d", i), outBuf[8'(base + i)], expQ[i]);
  endtask

  task automatic tReset();
    chk("R2", "txLine idle", txLine, 1);
    chk("R2", "regWrEn low", regWrEn, 0);
    chk("R2", "regRdEn low", regRdEn, 0);
  endtask

  // R3 R6 R7: unaddressed station claims a read to address 0
  task automatic tClaimRead();
    logic [7:0] req[$] = '{8'h00, 8'h05, 8'h02};
    logic [7:0] all[$];
    int base = outCnt, rd0 = rdCnt;
    all = req; all.push_back(8'h5F); all.push_back(8'h5C);
    expQ = '{8'h80, 8'h05, 8'h02, 8'h5F, 8'h5C};
    expQ.push_back(crcOf(all));
    sendAll(req); settle();
    compareOut("R3", base);
    chk("R6", "read strobes", rdCnt - rd0, 2);
    chk("R7", "reply crc", outBuf[8'(base + 5)], crcOf(all));
  endtask

  // R4: a taken header is passed on and its reply bytes skipped
  task automatic tBlocked();
    logic [7:0] req[$] = '{8'h80, 8'h10, 8'h01, 8'hAA, 8'hBB};
    int base = outCnt, rd0 = rdCnt;
    expQ = req;
    sendAll(req); settle();
    compareOut("R4", base);
    chk("R4", "no read", rdCnt - rd0, 0);
  endtask

  // R5: write with wrong CRC is not performed, header still claimed (R3)
  task automatic tBadCrc();
    logic [7:0] req[$] = '{8'h01, 8'h20, 8'h77};
    int base = outCnt, wr0 = wrCnt;
    logic [7:0] bad = crcOf(req) ^ 8'h01;
    req.push_back(bad);
    expQ = '{8'h81, 8'h20, 8'h77, bad};
    sendAll(req); settle();
    compareOut("R5", base);
    chk("R5", "no write on bad crc", wrCnt - wr0, 0);
  endtask

  task automatic tGoodWrite();
    logic [7:0] req[$] = '{8'h01, 8'h20, 8'h77};
    int base = outCnt, wr0 = wrCnt;
    logic [7:0] c = crcOf(req);
    req.push_back(c);
    expQ = '{8'h81, 8'h20, 8'h77, c};
    sendAll(req); settle();
    compareOut("R5", base);
    chk("R5", "one write", wrCnt - wr0, 1);
    chk("R5", "written value", regs[8'h20], 8'h77);
  endtask

  // R8: address assignment, then address 0 is no longer taken
  task automatic tAssign();
    logic [7:0] req[$] = '{8'h01, 8'h3B, 8'h85};
    logic [7:0] nxt[$] = '{8'h00, 8'h05, 8'h01, 8'hCC, 8'hDD};
    int base, wr0 = wrCnt, rd0;
    req.push_back(crcOf(req));
    sendAll(req); settle();
    chk("R8", "assign write", wrCnt - wr0, 1);
    base = outCnt; rd0 = rdCnt;
    expQ = nxt;
    sendAll(nxt); settle();
    compareOut("R8", base);
    chk("R8", "address 0 ignored", rdCnt - rd0, 0);
  endtask

  // R9 R6: read to own address wrapping past 0xFF
  task automatic tOwnRead();
    logic [7:0] req[$] = '{8'h0A, 8'hFF, 8'h02};
    logic [7:0] all[$];
    int base = outCnt, rd0 = rdCnt;
    all = req; all.push_back(8'hA5); all.push_back(8'h5A);
    expQ = all; expQ.push_back(crcOf(all));
    sendAll(req); settle();
    compareOut("R9", base);
    chk("R6", "wrap read count", rdCnt - rd0, 2);
  endtask

  task automatic tOtherAddr();
    logic [7:0] req[$] = '{8'h0D, 8'h20, 8'h11};
    int base = outCnt, wr0 = wrCnt;
    req.push_back(crcOf(req));
    expQ = req;
    sendAll(req); settle();
    compareOut("R9", base);
    chk("R9", "other address no write", wrCnt - wr0, 0);
  endtask

  // R10: broadcast write acted on, broadcast read not
  task automatic tBroadcast();
    logic [7:0] req[$] = '{8'h7F, 8'h30, 8'h3D};
    logic [7:0] rdq[$] = '{8'h7E, 8'h30, 8'h01, 8'hEE, 8'hEF};
    int base = outCnt, wr0 = wrCnt, rd0;
    req.push_back(crcOf(req));
    expQ = req;
    sendAll(req); settle();
    compareOut("R10", base);
    chk("R10", "broadcast write", wrCnt - wr0, 1);
    chk("R10", "broadcast value", regs[8'h30], 8'h3D);
    base = outCnt; rd0 = rdCnt;
    expQ = rdq;
    sendAll(rdq); settle();
    compareOut("R10", base);
    chk("R10", "broadcast read ignored", rdCnt - rd0, 0);
  endtask

  // R11: stalled partial packet is dropped by the parser
  task automatic tTimeout();
    logic [7:0] req[$] = '{8'h0A, 8'h20, 8'h01};
    logic [7:0] all[$];
    int base = outCnt, rd0 = rdCnt;
    all = req; all.push_back(8'h77);
    sendByte(8'h0A); sendByte(8'h40);
    repeat (30 * CPB) @(negedge clk);
    expQ = '{8'h0A, 8'h40};
    foreach (all[i]) expQ.push_back(all[i]);
    expQ.push_back(crcOf(all));
    sendAll(req); settle();
    compareOut("R11", base);
    chk("R11", "read after timeout", rdCnt - rd0, 1);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (10) @(negedge clk);
    tReset();
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    tReset();
    tClaimRead();
    tBlocked();
    tBadCrc();
    tGoodWrite();
    tAssign();
    tOwnRead();
    tOtherAddr();
    tBroadcast();
    tTimeout();
    done = 1;
    summary();
    $finish;
  end
endmodule